// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This block sits behind a clock-recovery stage. It takes one recovered bit per clock, qualified by a bit-valid strobe, and packs the bits into 10-bit characters. It then delivers the characters as 10-bit words, or as pairs that form 20-bit words. While framing is on, it watches every bit position for the positive-disparity comma. If a comma turns up off the current character boundary, the boundary jumps to the comma. The partial character that the comma overlaps is discarded, and the comma becomes the next delivered character.

Each delivered word comes with a one-cycle word-valid pulse. The word stays on the data output until the next pulse. A sync flag marks any word on the output that holds a comma. When framing is off, the block never looks for commas and cuts characters on a free-running 10-bit boundary. Characters pass through a one-character holding stage, so the character before a realigned comma can be discarded without producing a short or doubled word-valid.

Top module: `cdwa_aligner`

## Requirements
- R1: After synchronous active-high reset, `wordValid`, `syncFlag` and `wordOut` are all 0.
- R2: The first received bit of a character lands in bit 0 of that character, and later bits land in rising bit positions. A character is held back by one character time: it is delivered at the moment the following character boundary closes, with `wordValid` high in the cycle after that closing bit.
- R3: A cycle with `bitValid` low changes nothing. No bit is taken in, the boundary position does not move and no word is delivered.
- R4: A comma is a 10-bit character whose bits 0 and 1 are 0 and whose bits 2 to 6 are 1. Bits 7 to 9 are ignored. The inverted form (bits 0–1 = 1, bits 2–6 = 0) is never treated as a comma.
- R5: With framing on, a comma that completes on a bit that is not the current boundary moves the boundary to that bit. The partially assembled character before the comma is never delivered, and the comma itself is the next character delivered.
- R6: `syncFlag` is 1 exactly while the word on `wordOut` holds a comma in any of its characters, and 0 otherwise. This is the same in both widths.
- R7: Two `wordValid` pulses are always separated by at least 10 accepted bits, whether or not a realignment happens.
- R8: With `frameEn` low, no comma search takes place. Characters are cut every 10 accepted bits from the previous boundary.
- R9: With `wideMode` high (changed only under reset), a word holds two characters. The earlier character is in bits 9:0 and the later one in bits 19:10. A comma character always starts a new word in the lower half, and a lone lower character left waiting is dropped. With `wideMode` low, bits 19:10 are 0.
- R10: `wordOut` holds its value in every cycle in which `wordValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Recovered serial bit |
| bitValid | input | 1 | Qualifies `bitIn` in this cycle |
| frameEn | input | 1 | 1 = comma search and realignment on |
| wideMode | input | 1 | 1 = 20-bit words, 0 = 10-bit words |
| wordOut | output | 20 | Parallel word, first character in bits 9:0 |
| wordValid | output | 1 | One-cycle pulse when a new word is placed on `wordOut` |
| syncFlag | output | 1 | Word on `wordOut` holds a comma |

## Verification
Several properties are checked on every clock:
- The sync flag matches the comma content of the present word.
- The data output stays still between pulses.
- Pulse spacing stays at or above one character of accepted bits.
- An idle bit slot leaves the boundary counter unchanged.
- With framing off, the boundary advances one position per accepted bit.

Other behaviour is shown only by the bench's reference-model scenarios:
- Which character is discarded when a realignment occurs.
- The exact bit order inside a character.
- How pairs are formed and re-formed around commas in 20-bit mode.
- That the inverted comma is ignored.

// File: rtl/cdwa_pkg.sv
package cdwa_pkg;
  localparam int CHAR_W = 10;
  localparam int LANES = 2;
  localparam int WORD_W = CHAR_W * LANES;
  localparam int POS_W = $clog2(CHAR_W);

  // fixed positions of the comma inside a character (bit 0 = first bit received)
  localparam logic [CHAR_W-1:0] COMMA_MASK = 10'b00_0111_1111;
  localparam logic [CHAR_W-1:0] COMMA_VAL  = 10'b00_0111_1100;

  typedef struct packed {
    logic shift;     // take bitIn into the window
    logic loadHold;  // window becomes the held character
    logic loadLow;   // held character parks as the lower half of a wide word
    logic loadOut;   // a word is placed on the output
  } strobe_t;

  function automatic logic isComma(input logic [CHAR_W-1:0] c);
    return (c & COMMA_MASK) == COMMA_VAL;
  endfunction
endpackage

// File: rtl/cdwa_datapath.sv
module cdwa_datapath
  import cdwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bitIn,
  input  logic              wideMode,
  input  strobe_t           stb,
  output logic              matchRaw,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              syncFlag
);
  logic [CHAR_W-1:0] win;
  logic [CHAR_W-1:0] nextWin;
  logic [CHAR_W-1:0] holdChar;
  logic [CHAR_W-1:0] lowChar;
  logic [WORD_W-1:0] nextWord;
  logic [LANES-1:0]  laneComma;
  logic [LANES-1:0]  outLaneComma;

  // newest bit enters at the top, so the oldest bit sits in bit 0
  assign nextWin  = {bitIn, win[CHAR_W-1:1]};
  assign matchRaw = isComma(nextWin);
  assign nextWord = wideMode ? {holdChar, lowChar} : {{CHAR_W{1'b0}}, holdChar};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneComma[l]    = isComma(nextWord[l*CHAR_W +: CHAR_W]);
    assign outLaneComma[l] = isComma(wordOut[l*CHAR_W +: CHAR_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win       <= '1;  // all ones can never form a comma with stale bits
      holdChar  <= '0;
      lowChar   <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      syncFlag  <= 1'b0;
    end else begin
      wordValid <= stb.loadOut;
      if (stb.shift)    win      <= nextWin;
      if (stb.loadHold) holdChar <= nextWin;
      if (stb.loadLow)  lowChar  <= holdChar;
      if (stb.loadOut) begin
        wordOut  <= nextWord;
        syncFlag <= |laneComma;
      end
    end
  end

  // R1: reset clears the output side
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!wordValid && !syncFlag && wordOut == '0));
  // R6: flag tracks the comma content of the presented word
  a_r6_sync_matches: assert property (@(posedge clk) disable iff (rst)
    syncFlag == (|outLaneComma));
  // R10: data holds between pulses
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !wordValid |-> $stable(wordOut));
endmodule

// File: rtl/cdwa_control.sv
module cdwa_control
  import cdwa_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bitValid,
  input  logic    frameEn,
  input  logic    wideMode,
  input  logic    matchRaw,
  output strobe_t stb
);
  logic [POS_W-1:0] pos;
  logic holdValid, holdFlag, slotFull;
  logic boundary, match, realign, closeChar, emitChar, toLow;

  assign boundary  = (pos == POS_W'(CHAR_W - 1));
  assign match     = frameEn & matchRaw;
  assign realign   = bitValid & match & ~boundary;
  assign closeChar = bitValid & boundary;
  assign emitChar  = closeChar & holdValid;
  // a comma always opens a new wide word; otherwise fill the empty lower half
  assign toLow     = wideMode & (holdFlag | ~slotFull);

  always_comb begin
    stb          = '0;
    stb.shift    = bitValid;
    stb.loadHold = realign | closeChar;
    stb.loadLow  = emitChar & toLow;
    stb.loadOut  = emitChar & ~toLow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      holdValid <= 1'b0;
      holdFlag  <= 1'b0;
      slotFull  <= 1'b0;
    end else begin
      if (bitValid) pos <= (realign | closeChar) ? '0 : pos + 1'b1;
      if (stb.loadHold) begin
        holdValid <= 1'b1;
        holdFlag  <= match;
      end
      if (stb.loadLow)      slotFull <= 1'b1;
      else if (stb.loadOut) slotFull <= 1'b0;
    end
  end

  // spacing monitor: accepted bits since the last delivered word
  logic [5:0] gapCnt;
  always_ff @(posedge clk) begin
    if (rst)              gapCnt <= '0;
    else if (stb.loadOut) gapCnt <= '0;
    else if (bitValid && gapCnt != 6'h3f) gapCnt <= gapCnt + 1'b1;
  end

  a_r2_pos_range: assert property (@(posedge clk) disable iff (rst)
    pos < POS_W'(CHAR_W));
  a_r3_idle_still: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> $stable(pos));
  a_r7_spacing: assert property (@(posedge clk) disable iff (rst)
    stb.loadOut |-> gapCnt >= 6'(CHAR_W - 1));
  a_r8_free_run: assert property (@(posedge clk) disable iff (rst)
    (!frameEn && bitValid && !boundary) |=> pos == $past(pos) + 1'b1);
endmodule

// File: rtl/cdwa_aligner.sv
module cdwa_aligner
  import cdwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic              frameEn,
  input  logic              wideMode,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              syncFlag
);
  strobe_t stb;
  logic    matchRaw;

  cdwa_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .frameEn  (frameEn),
    .wideMode (wideMode),
    .matchRaw (matchRaw),
    .stb      (stb)
  );

  cdwa_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .bitIn     (bitIn),
    .wideMode  (wideMode),
    .stb       (stb),
    .matchRaw  (matchRaw),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .syncFlag  (syncFlag)
  );
endmodule

// File: tb/tb_cdwa_aligner.sv
module tb_cdwa_aligner;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitIn = 1'b0, bitValid = 1'b0, frameEn = 1'b0, wideMode = 1'b0;
  logic [19:0] wordOut;
  logic wordValid, syncFlag;

  int compared = 0, mismatched = 0;
  string curTag = "R1 reset";

  always #(CLK_P/2) clk = ~clk;

  cdwa_aligner dut (.*);

  // ---------------- behavioural reference model ----------------
  bit recent[$];           // last up-to-10 accepted bits, oldest first
  int inChar;              // bits accepted since the current boundary
  bit [9:0] pendVal[$];    // characters waiting for the next boundary
  bit pendCm[$];
  bit [9:0] lowQ[$];       // lower half waiting for a partner (wide mode)
  bit [19:0] expWord;
  bit expValid, expSync;

  function automatic bit commaOf(bit [9:0] c);
    return c[0] == 0 && c[1] == 0 && c[6:2] == 5'b11111;
  endfunction

  function automatic bit [9:0] packRecent();
    bit [9:0] c;
    for (int k = 0; k < 10; k++) c[k] = recent[k];
    return c;
  endfunction

  task automatic deliver(bit [9:0] c, bit cm);
    if (!wideMode) begin
      expWord = {10'b0, c}; expValid = 1; expSync = commaOf(c);
    end else if (cm || lowQ.size() == 0) begin
      lowQ.delete(); lowQ.push_back(c);
    end else begin
      expWord = {c, lowQ[0]}; expValid = 1;
      expSync = commaOf(c) || commaOf(lowQ[0]);
      lowQ.delete();
    end
  endtask

  always @(posedge clk) begin
    expValid = 0;
    if (rst) begin
      recent.delete(); pendVal.delete(); pendCm.delete(); lowQ.delete();
      inChar = 0; expWord = '0; expSync = 0;
    end else if (bitValid) begin
      bit hit, edge10;
      recent.push_back(bitIn);
      if (recent.size() > 10) void'(recent.pop_front());
      hit = frameEn && recent.size() == 10 && commaOf(packRecent());
      edge10 = (inChar + 1 == 10);
      if (hit && !edge10) begin
        pendVal.delete(); pendCm.delete();      // R5: overlapped partial dropped
        pendVal.push_back(packRecent()); pendCm.push_back(1);
        inChar = 0;
      end else if (edge10) begin
        if (pendVal.size() > 0) deliver(pendVal.pop_front(), pendCm.pop_front());
        pendVal.push_back(packRecent()); pendCm.push_back(hit);
        inChar = 0;
      end else begin
        inChar++;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic compare();
    compared++;
    if (wordValid !== expValid || syncFlag !== expSync ||
        (expValid && wordOut !== expWord) || wordOut !== expWord) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b sync=%0b word=%05h, expected valid=%0b sync=%0b word=%05h",
               curTag, wordValid, syncFlag, wordOut, expValid, expSync, expWord);
    end
  endtask

  task automatic step(logic v, logic b);
    @(negedge clk);
    compare();
    bitValid = v; bitIn = b;
  endtask

  task automatic doReset(logic wide, logic fr);
    rst = 1; wideMode = wide; frameEn = fr;
    step(0, 0); step(0, 0);
    rst = 0;
    step(0, 0);
    // R1: explicit reset-state check
    compared++;
    if (wordValid !== 0 || syncFlag !== 0 || wordOut !== '0) begin
      mismatched++;
      $display("FAIL R1 reset state: got valid=%0b sync=%0b word=%05h, expected 0 0 00000",
               wordValid, syncFlag, wordOut);
    end
  endtask

  int gapPct = 0;
  task automatic sendBit(logic b);
    while ($urandom_range(99) < gapPct) step(0, 1'($urandom));  // R3 idle slots
    step(1, b);
  endtask

  task automatic sendChar(logic [9:0] c);
    for (int k = 0; k < 10; k++) sendBit(c[k]);
  endtask

  function automatic logic [9:0] commaChar();
    return {3'($urandom), 7'b1111100};
  endfunction

  task automatic mixedStream(int nChars, bit inverted);
    for (int i = 0; i < nChars; i++) begin
      int r = $urandom_range(9);
      if (r < 2) begin
        for (int j = 0; j < int'($urandom_range(9)); j++) sendBit(1'($urandom));
        sendChar(inverted ? ~commaChar() : commaChar());
      end else if (r < 4) begin
        sendChar(inverted ? ~commaChar() : commaChar());
      end else begin
        sendChar(10'($urandom) | 10'h004);
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 25; i++) step(1, 1'b1);
    for (int i = 0; i < 3; i++) step(0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    doReset(0, 0);

    curTag = "R2/R8 unframed 10-bit";
    for (int i = 0; i < 200; i++) sendBit(1'($urandom));
    drain();

    curTag = "R8 commas ignored with framing off";
    mixedStream(40, 0); drain();

    doReset(0, 1);
    curTag = "R4/R5/R6 framed 10-bit realign";
    mixedStream(60, 0); drain();

    curTag = "R5 comma one bit past boundary";
    sendChar(10'h2a5); sendBit(1'b0); sendChar(commaChar()); sendChar(10'h155);
    sendBit(1); sendBit(0); sendBit(1); sendChar(commaChar()); sendChar(10'h0f3);
    drain();

    curTag = "R4 inverted comma not matched";
    mixedStream(40, 1); drain();

    curTag = "R3/R7 idle gaps in bit stream";
    gapPct = 35;
    mixedStream(50, 0); drain();
    gapPct = 0;

    doReset(1, 1);
    curTag = "R9/R6 framed 20-bit";
    mixedStream(80, 0); drain();
    curTag = "R9 back-to-back commas 20-bit";
    sendChar(commaChar()); sendChar(commaChar()); sendChar(10'h3c1);
    sendBit(0); sendBit(1); sendChar(commaChar()); sendChar(10'h1aa); sendChar(10'h2d4);
    drain();

    doReset(1, 0);
    curTag = "R9/R8 unframed 20-bit";
    mixedStream(50, 0); drain();

    curTag = "R10 hold while idle";
    for (int i = 0; i < 20; i++) step(0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    mismatched++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule